// File: doc/BRIEF.md
# Single-Outstanding DMA Request Sequencer

This block sits between a DMA request source and a memory directory. Each load or store request it accepts becomes exactly one read or write message toward the directory. The controller then waits for the answer that belongs to that message. A data response completes a load and hands the returned block back to the requester. An acknowledge completes a store and signals write completion.

Only one transaction is in flight at a time. The controller keeps a single tracking entry for the open transaction, which holds the line address and the data block. It tracks whether that transaction is a read or a write with two distinct busy states. While it is busy, new requests wait in their source queue: the request input is simply not ready, so nothing is lost and the request is taken once the controller is idle again.

Every outgoing message leaves a fixed, parameterised number of cycles after its request was accepted. Malformed input does not disturb the flow. A request of an unknown kind, or a response that is unknown, unexpected or for the wrong line, is discarded and raises a sticky error flag.

Top module: `dma_seq_ctrl`

## Requirements
- R1: After reset the controller is idle: `rq_ready` is 1, `dir_valid`, `rd_done`, `wr_done`, `req_err` and `rsp_err` are 0, and `rsp_ready` is always 1.
- R2: A request accepted with `rq_kind` = 0 (load) produces a directory message with `dir_kind` = 0 (read). The message carries `rq_addr`, `rq_data` and `rq_len` unchanged and `dir_src` equal to the `REQ_ID` parameter (default 5). The controller enters its read-busy state.
- R3: A request accepted with `rq_kind` = 1 (store) produces a directory message with `dir_kind` = 1 (write), carrying the same copied fields. The controller enters its write-busy state.
- R4: `dir_valid` first goes high exactly `ISSUE_DLY` (default 6) clock edges after the edge that accepted the request. It then stays high with all message fields stable until `dir_ready` is seen high at an edge.
- R5: From acceptance until completion `rq_ready` is 0. A request held valid during that time is neither taken nor lost: it is accepted on the first edge after completion and issued with its own fields.
- R6: In read-busy, after the message was sent, a response with `rsp_kind` = 1 (data) for the open line completes the load. One cycle later `rd_done` pulses for one cycle, with `rd_line` equal to the request address with its low 6 bits cleared and `rd_data` equal to `rsp_data`. The controller is idle again.
- R7: In write-busy, after the message was sent, a response with `rsp_kind` = 2 (acknowledge) for the open line completes the store. One cycle later `wr_done` pulses for one cycle with `wr_line` equal to the line address, and the controller is idle again.
- R8: Responses are matched on the line address only: the low 6 bits of `rsp_addr` are ignored when it is compared with the open line.
- R9: A request accepted with `rq_kind` of 2 or 3 is consumed. It produces no directory message, leaves the controller idle, and sets `req_err`, which stays set until reset.
- R10: A response that arrives while idle, has the wrong kind for the busy state, has an unknown kind (0 or 3), or names another line is dropped. It produces no completion pulse and sets `rsp_err`, which stays set until reset. The controller stays in its state, and a later correct response still completes the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Request accepted on this edge when valid |
| rq_kind | input | 2 | 0 load, 1 store, 2/3 illegal |
| rq_addr | input | AW | Physical byte address |
| rq_data | input | DW | Data block |
| rq_len | input | LW | Byte length |
| dir_valid | output | 1 | Directory message present |
| dir_ready | input | 1 | Directory accepts message |
| dir_kind | output | 1 | 0 read, 1 write |
| dir_addr | output | AW | Physical address copied from request |
| dir_src | output | IW | Requester identifier |
| dir_data | output | DW | Data block copied from request |
| dir_len | output | LW | Byte length copied from request |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Always 1, responses always popped |
| rsp_kind | input | 2 | 1 data, 2 acknowledge, 0/3 illegal |
| rsp_addr | input | AW | Response address |
| rsp_data | input | DW | Returned data block |
| rd_done | output | 1 | Load completion pulse |
| rd_line | output | AW | Line address of completed load |
| rd_data | output | DW | Returned data of completed load |
| wr_done | output | 1 | Store completion pulse |
| wr_line | output | AW | Line address of completed store |
| req_err | output | 1 | Sticky illegal-request flag |
| rsp_err | output | 1 | Sticky protocol-error flag |

## Verification
The bound checker watches the invariants that hold on every cycle. It confirms that the request input is closed in both busy states and that the outgoing message is held stable under back-pressure. It also counts the exact issue gap after each legal acceptance, checks that every completion pulse follows a response of the matching kind, that the two pulses never coincide, and that both error flags are sticky. Only the bench scenarios can show the rest. These are that a stalled request is later issued with its own fields, that copied fields and line addresses carry the right values, that line matching ignores the offset bits, and that a dropped response leaves the transaction open for a later correct one.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_BUSY_RD = 2'd1,
        ST_BUSY_WR = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2,
        EV_BAD   = 2'd3
    } rq_event_e;

    typedef enum logic [1:0] {
        RE_NONE = 2'd0,
        RE_DATA = 2'd1,
        RE_ACK  = 2'd2,
        RE_BAD  = 2'd3
    } rsp_event_e;

    localparam logic [1:0] RQ_LOAD  = 2'd0;
    localparam logic [1:0] RQ_STORE = 2'd1;
    localparam logic [1:0] RSP_DATA = 2'd1;
    localparam logic [1:0] RSP_ACK  = 2'd2;

    localparam logic DIR_READ  = 1'b0;
    localparam logic DIR_WRITE = 1'b1;

    function automatic rq_event_e rq_classify(input logic fire, input logic [1:0] kind);
        if (!fire)                 return EV_NONE;
        else if (kind == RQ_LOAD)  return EV_READ;
        else if (kind == RQ_STORE) return EV_WRITE;
        else                       return EV_BAD;
    endfunction

    function automatic rsp_event_e rsp_classify(input logic vld, input logic [1:0] kind);
        if (!vld)                  return RE_NONE;
        else if (kind == RSP_DATA) return RE_DATA;
        else if (kind == RSP_ACK)  return RE_ACK;
        else                       return RE_BAD;
    endfunction

endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
    import dma_seq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LINE_BITS = 6
) (
    input  logic          rq_fire,
    input  logic [1:0]    rq_kind,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_kind,
    input  logic [AW-1:0] rsp_addr,
    input  logic [AW-1:0] ent_line,
    output rq_event_e     rq_ev,
    output rsp_event_e    rsp_ev,
    output logic          line_hit
);
    localparam logic [AW-1:0] OFS_MASK = AW'((64'd1 << LINE_BITS) - 64'd1);

    always_comb begin
        rq_ev    = rq_classify(rq_fire, rq_kind);
        rsp_ev   = rsp_classify(rsp_valid, rsp_kind);
        line_hit = ((rsp_addr & ~OFS_MASK) == ent_line);
    end
endmodule

// File: rtl/dma_seq_entry.sv
module dma_seq_entry #(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int LINE_BITS = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic [AW-1:0] alloc_addr,
    input  logic          fill,
    input  logic [DW-1:0] fill_data,
    input  logic          release_ent,
    output logic          ent_valid,
    output logic [AW-1:0] ent_line,
    output logic [DW-1:0] ent_data
);
    localparam logic [AW-1:0] OFS_MASK = AW'((64'd1 << LINE_BITS) - 64'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= 1'b0;
            ent_line  <= '0;
            ent_data  <= '0;
        end else begin
            if (alloc) begin
                ent_valid <= 1'b1;
                ent_line  <= alloc_addr & ~OFS_MASK;
            end else if (release_ent) begin
                ent_valid <= 1'b0;
            end
            if (fill) ent_data <= fill_data;
        end
    end
endmodule

// File: rtl/dma_seq_issue.sv
module dma_seq_issue #(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int LW        = 7,
    parameter int ISSUE_DLY = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          s_kind,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_data,
    input  logic [LW-1:0] s_len,
    input  logic          dir_ready,
    output logic          dir_valid,
    output logic          dir_kind,
    output logic [AW-1:0] dir_addr,
    output logic [DW-1:0] dir_data,
    output logic [LW-1:0] dir_len,
    output logic          pending,
    output logic          sent
);
    localparam int CNT_W = (ISSUE_DLY < 2) ? 1 : $clog2(ISSUE_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ISSUE_DLY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             arm_q;

    assign pending = arm_q | dir_valid;
    assign sent    = dir_valid & dir_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            arm_q     <= 1'b0;
            dir_valid <= 1'b0;
            dir_kind  <= 1'b0;
            dir_addr  <= '0;
            dir_data  <= '0;
            dir_len   <= '0;
        end else begin
            if (start) begin
                cnt_q    <= CNT_LOAD;
                arm_q    <= 1'b1;
                dir_kind <= s_kind;
                dir_addr <= s_addr;
                dir_data <= s_data;
                dir_len  <= s_len;
            end else if (arm_q) begin
                if (cnt_q == CNT_LAST) begin
                    arm_q     <= 1'b0;
                    dir_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_LAST;
                end
            end
            if (sent) dir_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int AW                 = 32,
    parameter int DW                 = 64,
    parameter int LW                 = 7,
    parameter int IW                 = 4,
    parameter int LINE_BITS          = 6,
    parameter int ISSUE_DLY          = 6,
    parameter logic [IW-1:0] REQ_ID  = 4'd5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rq_valid,
    output logic          rq_ready,
    input  logic [1:0]    rq_kind,
    input  logic [AW-1:0] rq_addr,
    input  logic [DW-1:0] rq_data,
    input  logic [LW-1:0] rq_len,
    output logic          dir_valid,
    input  logic          dir_ready,
    output logic          dir_kind,
    output logic [AW-1:0] dir_addr,
    output logic [IW-1:0] dir_src,
    output logic [DW-1:0] dir_data,
    output logic [LW-1:0] dir_len,
    input  logic          rsp_valid,
    output logic          rsp_ready,
    input  logic [1:0]    rsp_kind,
    input  logic [AW-1:0] rsp_addr,
    input  logic [DW-1:0] rsp_data,
    output logic          rd_done,
    output logic [AW-1:0] rd_line,
    output logic [DW-1:0] rd_data,
    output logic          wr_done,
    output logic [AW-1:0] wr_line,
    output logic          req_err,
    output logic          rsp_err
);
    seq_state_e state_q, state_d;
    rq_event_e  rq_ev;
    rsp_event_e rsp_ev;
    logic       line_hit, issue_pend, issue_sent, issued_q;
    logic       start, done_rd, done_wr;
    logic       ent_valid;
    logic [AW-1:0] ent_line;

    assign rsp_ready = 1'b1;
    assign dir_src   = REQ_ID;
    assign rq_ready  = (state_q == ST_READY) && !issue_pend;
    assign start     = (rq_ev == EV_READ) || (rq_ev == EV_WRITE);

    dma_seq_decode #(.AW(AW), .LINE_BITS(LINE_BITS)) u_dec (
        .rq_fire  (rq_valid & rq_ready),
        .rq_kind  (rq_kind),
        .rsp_valid(rsp_valid),
        .rsp_kind (rsp_kind),
        .rsp_addr (rsp_addr),
        .ent_line (ent_line),
        .rq_ev    (rq_ev),
        .rsp_ev   (rsp_ev),
        .line_hit (line_hit)
    );

    dma_seq_issue #(.AW(AW), .DW(DW), .LW(LW), .ISSUE_DLY(ISSUE_DLY)) u_iss (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .s_kind   ((rq_ev == EV_WRITE) ? DIR_WRITE : DIR_READ),
        .s_addr   (rq_addr),
        .s_data   (rq_data),
        .s_len    (rq_len),
        .dir_ready(dir_ready),
        .dir_valid(dir_valid),
        .dir_kind (dir_kind),
        .dir_addr (dir_addr),
        .dir_data (dir_data),
        .dir_len  (dir_len),
        .pending  (issue_pend),
        .sent     (issue_sent)
    );

    dma_seq_entry #(.AW(AW), .DW(DW), .LINE_BITS(LINE_BITS)) u_ent (
        .clk        (clk),
        .rst        (rst),
        .alloc      (start),
        .alloc_addr (rq_addr),
        .fill       (done_rd),
        .fill_data  (rsp_data),
        .release_ent(done_rd | done_wr),
        .ent_valid  (ent_valid),
        .ent_line   (ent_line),
        .ent_data   (rd_data)
    );

    // A response only counts once the message went out and the entry is live.
    always_comb begin
        done_rd = (rsp_ev == RE_DATA) && (state_q == ST_BUSY_RD) && issued_q && ent_valid && line_hit;
        done_wr = (rsp_ev == RE_ACK)  && (state_q == ST_BUSY_WR) && issued_q && ent_valid && line_hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (rq_ev == EV_READ)       state_d = ST_BUSY_RD;
                else if (rq_ev == EV_WRITE) state_d = ST_BUSY_WR;
            end
            ST_BUSY_RD: if (done_rd) state_d = ST_READY;
            ST_BUSY_WR: if (done_wr) state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_READY;
            issued_q <= 1'b0;
            rd_done  <= 1'b0;
            wr_done  <= 1'b0;
            req_err  <= 1'b0;
            rsp_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start)           issued_q <= 1'b0;
            else if (issue_sent) issued_q <= 1'b1;
            rd_done <= done_rd;
            wr_done <= done_wr;
            if (rq_ev == EV_BAD) req_err <= 1'b1;
            if ((rsp_ev != RE_NONE) && !done_rd && !done_wr) rsp_err <= 1'b1;
        end
    end

    assign rd_line = ent_line;
    assign wr_line = ent_line;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int ISSUE_DLY = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          rq_valid,
    input logic          rq_ready,
    input logic [1:0]    rq_kind,
    input logic          dir_valid,
    input logic          dir_ready,
    input logic          dir_kind,
    input logic [AW-1:0] dir_addr,
    input logic          rsp_valid,
    input logic [1:0]    rsp_kind,
    input logic          rd_done,
    input logic          wr_done,
    input logic          req_err,
    input logic          rsp_err,
    input seq_state_e    st
);
    int unsigned gap_q;
    logic        legal_acc;

    assign legal_acc = rq_valid && rq_ready && (rq_kind == RQ_LOAD || rq_kind == RQ_STORE);

    always_ff @(posedge clk) begin
        if (rst)            gap_q <= 0;
        else if (legal_acc) gap_q <= 0;
        else if (gap_q < 32'hFFFF) gap_q <= gap_q + 1;
    end

    assert_closed_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (st != ST_READY) |-> !rq_ready);
    assert_hold_msg_R4: assert property (@(posedge clk) disable iff (rst)
        (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_addr) && $stable(dir_kind)));
    assert_issue_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_valid) |-> (gap_q == ISSUE_DLY));
    assert_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && rq_ready && rq_kind == RQ_LOAD) |=> (st == ST_BUSY_RD));
    assert_store_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && rq_ready && rq_kind == RQ_STORE) |=> (st == ST_BUSY_WR));
    assert_rd_cause_R6: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> $past(rsp_valid && rsp_kind == RSP_DATA));
    assert_wr_cause_R7: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> $past(rsp_valid && rsp_kind == RSP_ACK));
    assert_single_done_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd_done && wr_done));
    assert_bad_req_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && rq_ready && rq_kind[1]) |=> (st == ST_READY && req_err));
    assert_req_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        req_err |=> req_err);
    assert_rsp_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> rsp_err);
endmodule

bind dma_seq_ctrl dma_seq_chk #(.AW(AW), .ISSUE_DLY(ISSUE_DLY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rq_kind  (rq_kind),
    .dir_valid(dir_valid),
    .dir_ready(dir_ready),
    .dir_kind (dir_kind),
    .dir_addr (dir_addr),
    .rsp_valid(rsp_valid),
    .rsp_kind (rsp_kind),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .req_err  (req_err),
    .rsp_err  (rsp_err),
    .st       (state_q)
);

// File: tb/sim_dma_seq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_seq_ctrl;
    localparam int AW = 32, DW = 64, LW = 7, IW = 4, DLY = 6;
    localparam logic [IW-1:0] RID = 4'd5;
    localparam logic [AW-1:0] LMASK = 32'hFFFF_FFC0;

    logic clk = 0, rst = 1;
    logic rq_valid = 0, rq_ready;
    logic [1:0] rq_kind = 0;
    logic [AW-1:0] rq_addr = 0;
    logic [DW-1:0] rq_data = 0;
    logic [LW-1:0] rq_len = 0;
    logic dir_valid, dir_ready = 1, dir_kind;
    logic [AW-1:0] dir_addr;
    logic [IW-1:0] dir_src;
    logic [DW-1:0] dir_data;
    logic [LW-1:0] dir_len;
    logic rsp_valid = 0, rsp_ready;
    logic [1:0] rsp_kind = 0;
    logic [AW-1:0] rsp_addr = 0;
    logic [DW-1:0] rsp_data = 0;
    logic rd_done, wr_done, req_err, rsp_err;
    logic [AW-1:0] rd_line, wr_line;
    logic [DW-1:0] rd_data;

    always #5 clk = ~clk;

    dma_seq_ctrl #(.AW(AW), .DW(DW), .LW(LW), .IW(IW), .ISSUE_DLY(DLY), .REQ_ID(RID)) u0 (
        .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind),
        .rq_addr(rq_addr), .rq_data(rq_data), .rq_len(rq_len), .dir_valid(dir_valid),
        .dir_ready(dir_ready), .dir_kind(dir_kind), .dir_addr(dir_addr), .dir_src(dir_src),
        .dir_data(dir_data), .dir_len(dir_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rd_done(rd_done),
        .rd_line(rd_line), .rd_data(rd_data), .wr_done(wr_done), .wr_line(wr_line),
        .req_err(req_err), .rsp_err(rsp_err)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
            $finish;
        end
    end

    typedef struct packed {
        logic          store;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [LW-1:0] len;
        logic [5:0]    ofs;
        logic [1:0]    hold;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{1'b0, 32'h0000_1040, 64'h1111_2222_3333_4444, 7'd64, 6'd0,  2'd0},
        '{1'b1, 32'h8000_0FC4, 64'hDEAD_BEEF_0000_0001, 7'd4,  6'd17, 2'd0},
        '{1'b0, 32'h1234_567F, 64'h0F0F_0F0F_F0F0_F0F0, 7'd1,  6'd63, 2'd2},
        '{1'b1, 32'hFFFF_FFC0, 64'h0,                   7'd127,6'd5,  2'd3},
        '{1'b0, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 7'd8,  6'd32, 2'd1}
    };

    task automatic do_reset();
        rst = 1; rq_valid = 0; rsp_valid = 0; dir_ready = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    // Present a request at a negedge and return at the negedge after the accepting edge.
    task automatic put_req(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LW-1:0] l);
        rq_valid = 1; rq_kind = k; rq_addr = a; rq_data = d; rq_len = l;
        while (!rq_ready) @(negedge clk);
        @(negedge clk);
        rq_valid = 0;
    endtask

    // Follow the issue countdown, check the message, then let it be taken.
    task automatic see_issue(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [LW-1:0] l, input int hold, input string tag);
        dir_ready = (hold == 0);
        for (int i = 1; i <= DLY; i++) begin
            @(negedge clk);
            chk(dir_valid == (i == DLY), "R4 issue gap", {63'd0, dir_valid}, {63'd0, i == DLY});
        end
        chk(dir_kind == k, {tag, " kind"}, {63'd0, dir_kind}, {63'd0, k});
        chk(dir_addr == a, {tag, " addr"}, {32'd0, dir_addr}, {32'd0, a});
        chk(dir_data == d, {tag, " data"}, dir_data, d);
        chk(dir_len == l, {tag, " len"}, {57'd0, dir_len}, {57'd0, l});
        chk(dir_src == RID, {tag, " src"}, {60'd0, dir_src}, {60'd0, RID});
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(dir_valid && dir_addr == a, "R4 hold under backpressure", {32'd0, dir_addr}, {32'd0, a});
        end
        dir_ready = 1;
        @(negedge clk);
        chk(!dir_valid, "R4 drop after handshake", {63'd0, dir_valid}, 64'd0);
    endtask

    task automatic respond(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        rsp_valid = 1; rsp_kind = k; rsp_addr = a; rsp_data = d;
        @(negedge clk);
        rsp_valid = 0;
    endtask

    initial begin
        do_reset();
        // R1 idle after reset
        chk(rq_ready && rsp_ready, "R1 ready after reset", {62'd0, rq_ready, rsp_ready}, 64'd3);
        chk(!dir_valid && !rd_done && !wr_done, "R1 outputs quiet", {61'd0, dir_valid, rd_done, wr_done}, 64'd0);
        chk(!req_err && !rsp_err, "R1 errors clear", {62'd0, req_err, rsp_err}, 64'd0);

        // Table walk: R2, R3, R4, R6, R7, R8
        for (int v = 0; v < 5; v++) begin
            vec_t e = VEC[v];
            logic [AW-1:0] ln = e.addr & LMASK;
            put_req(e.store ? 2'd1 : 2'd0, e.addr, e.data, e.len);
            chk(!rq_ready, "R5 closed while busy", {63'd0, rq_ready}, 64'd0);
            see_issue(e.store, e.addr, e.data, e.len, int'(e.hold), e.store ? "R3" : "R2");
            respond(e.store ? 2'd2 : 2'd1, ln | {26'd0, e.ofs}, ~e.data);
            if (e.store) begin
                chk(wr_done && !rd_done, "R7 write done pulse", {62'd0, wr_done, rd_done}, 64'd2);
                chk(wr_line == ln, "R8 write line", {32'd0, wr_line}, {32'd0, ln});
            end else begin
                chk(rd_done && !wr_done, "R6 read done pulse", {62'd0, rd_done, wr_done}, 64'd2);
                chk(rd_line == ln, "R8 read line", {32'd0, rd_line}, {32'd0, ln});
                chk(rd_data == ~e.data, "R6 read data", rd_data, ~e.data);
            end
            @(negedge clk);
            chk(!rd_done && !wr_done && rq_ready, "R6 R7 single pulse then idle",
                {61'd0, rd_done, wr_done, rq_ready}, 64'd1);
        end
        chk(!rsp_err && !req_err, "R10 no error on clean traffic", {62'd0, rsp_err, req_err}, 64'd0);

        // R5: second request held during busy, then taken intact
        put_req(2'd0, 32'h0000_2000, 64'hA5, 7'd3);
        rq_valid = 1; rq_kind = 2'd1; rq_addr = 32'h0000_3010; rq_data = 64'h5A; rq_len = 7'd9;
        see_issue(1'b0, 32'h0000_2000, 64'hA5, 7'd3, 0, "R5 first");
        chk(!rq_ready, "R5 stalled not taken", {63'd0, rq_ready}, 64'd0);
        respond(2'd1, 32'h0000_2000, 64'h77);
        chk(rd_done && rq_ready, "R5 completes then reopens", {62'd0, rd_done, rq_ready}, 64'd3);
        @(negedge clk);
        rq_valid = 0;
        chk(!rq_ready, "R5 held request taken", {63'd0, rq_ready}, 64'd0);
        see_issue(1'b1, 32'h0000_3010, 64'h5A, 7'd9, 0, "R5 second");
        respond(2'd2, 32'h0000_3000, 64'h0);
        chk(wr_done && wr_line == 32'h0000_3000, "R5 second completes", {32'd0, wr_line}, 64'h3000);

        // R9: illegal request kind
        do_reset();
        put_req(2'd2, 32'h0000_4000, 64'h1, 7'd1);
        chk(req_err && rq_ready, "R9 flag set and still idle", {62'd0, req_err, rq_ready}, 64'd3);
        begin
            bit seen = 0;
            for (int i = 0; i < DLY + 3; i++) begin @(negedge clk); seen |= dir_valid; end
            chk(!seen, "R9 no directory message", {63'd0, seen}, 64'd0);
        end
        put_req(2'd3, 32'h0000_4000, 64'h1, 7'd1);
        chk(req_err && !rsp_err, "R9 flag sticky", {62'd0, req_err, rsp_err}, 64'd2);

        // R10: response while idle
        do_reset();
        respond(2'd2, 32'h0000_5000, 64'h0);
        chk(rsp_err && !wr_done && rq_ready, "R10 idle response dropped",
            {61'd0, rsp_err, wr_done, rq_ready}, 64'd5);

        // R10: wrong kind, unknown kind, wrong line in read-busy, then correct completion
        do_reset();
        put_req(2'd0, 32'h0000_6008, 64'hC0FFEE, 7'd2);
        see_issue(1'b0, 32'h0000_6008, 64'hC0FFEE, 7'd2, 0, "R10 setup");
        respond(2'd2, 32'h0000_6000, 64'h0);
        chk(rsp_err && !wr_done && !rd_done && !rq_ready, "R10 ack in read-busy dropped",
            {60'd0, rsp_err, wr_done, rd_done, rq_ready}, 64'd8);
        respond(2'd3, 32'h0000_6000, 64'h0);
        chk(!rd_done && !rq_ready, "R10 unknown kind dropped", {62'd0, rd_done, rq_ready}, 64'd0);
        respond(2'd1, 32'h0000_6040, 64'h9);
        chk(!rd_done && !rq_ready, "R10 other line dropped", {62'd0, rd_done, rq_ready}, 64'd0);
        respond(2'd1, 32'h0000_603F, 64'h42);
        chk(rd_done && rd_data == 64'h42, "R10 later correct data completes", rd_data, 64'h42);
        chk(rsp_err, "R10 flag sticky", {63'd0, rsp_err}, 64'd1);

        // R10: data response in write-busy
        do_reset();
        put_req(2'd1, 32'h0000_7000, 64'h3, 7'd4);
        see_issue(1'b1, 32'h0000_7000, 64'h3, 7'd4, 0, "R10 write setup");
        respond(2'd1, 32'h0000_7000, 64'h0);
        chk(rsp_err && !rd_done && !rq_ready, "R10 data in write-busy dropped",
            {61'd0, rsp_err, rd_done, rq_ready}, 64'd4);
        respond(2'd2, 32'h0000_7000, 64'h0);
        chk(wr_done, "R7 ack after dropped data", {63'd0, wr_done}, 64'd1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule